// File: doc/BRIEF.md
# Dual-Core Operating-Point Sequencer

Two cores each ask for an operating point. An operating point is a frequency ratio paired with a 7-bit voltage code. The package runs both cores at a single point, so this block reduces the two requests to one package target. It then moves the shared outputs to that target in a safe order. When the frequency rises, the voltage code climbs one code at a time and the PLL is asked to relock only after the voltage has arrived. When the frequency falls, the PLL relocks first and the voltage then walks down. The busy output stays high for the whole move, so that the surrounding bus logic can hold off snoops.

An extended-idle hint replaces the requested target with a fixed lowest point. When the hint drops, the point the cores are asking for becomes the target again. While the package is in a sleep state its clocks are gone, so the sequencer freezes in place. No transition starts or advances until the sleep input is released. A request that changes during a transition does not disturb it. The new target is taken up once the current move has finished.

Top module: `pstate_coord`

## Requirements
- R1: The package target takes the larger of the two requested ratios together with the voltage code of the core that asked for it. On equal ratios it takes the larger of the two voltage codes.
- R2: On a ratio increase, the voltage code first reaches the target code. Only then does `ratio_out` change, and the move completes when `pll_locked` is sampled high.
- R3: On a ratio decrease, `ratio_out` changes first, at the same time as `busy` rises. The voltage code starts stepping down only after `pll_locked` is sampled high.
- R4: `vid_out` changes by exactly one code per change. Consecutive changes within one move are `step_cycles` cycles apart, and a value of 0 counts as 1.
- R5: `busy` is high from the first cycle of a move until `vid_out` and `ratio_out` equal the target and the lock has been seen. The outputs change only while `busy` is high, and no move starts when the target equals the present point.
- R6: `relock_req` rises together with the change of `ratio_out` and stays high until `pll_locked` is sampled high. A `pll_locked` pulse outside a relock has no effect.
- R7: A target that changes during a move is deferred. The running move completes to its original target, `busy` drops for one cycle, and then a new move to the latest target starts.
- R8: While `ext_idle` is high, the target is the lowest point (`LOW_RATIO`, `LOW_VID`, 6 and 10 by default). When `ext_idle` falls, the target returns to the resolved core requests.
- R9: While `pkg_sleep` is high, `vid_out`, `ratio_out`, `busy` and `relock_req` hold their values, and no new move starts.
- R10: After reset, `vid_out` is `LOW_VID`, `ratio_out` is `LOW_RATIO`, and `busy` and `relock_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core0_ratio | input | 5 | Core 0 requested frequency ratio |
| core0_vid | input | 7 | Core 0 requested voltage code |
| core1_ratio | input | 5 | Core 1 requested frequency ratio |
| core1_vid | input | 7 | Core 1 requested voltage code |
| ext_idle | input | 1 | Extended idle: force the lowest point |
| pkg_sleep | input | 1 | Package in a clock-stopped sleep state: freeze |
| pll_locked | input | 1 | PLL lock strobe |
| step_cycles | input | 8 | Cycles per voltage step (0 means 1) |
| vid_out | output | 7 | Voltage code to the regulator |
| ratio_out | output | 5 | Frequency ratio to the PLL |
| relock_req | output | 1 | Request for the PLL to relock to `ratio_out` |
| busy | output | 1 | Transition in progress; blocks snoops |

## Verification
The ordering properties assume monotone requests: a core asking for a higher ratio never asks for a lower voltage code than the other core. Without that, an upward move could step the voltage down and a downward move could step it up. Every request in the stimulus keeps to this rule. The properties also assume that `pll_locked` matters only while a relock is pending. The bench drives lock pulses from a small PLL model that answers `relock_req`, and it injects one stray pulse while idle to show that the pulse is ignored. `step_cycles` is held constant for the length of each move, so that the step spacing is well defined.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    localparam int RATIO_W = 5;
    localparam int VID_W   = 7;
    localparam int CNT_W   = 8;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [VID_W-1:0]   vid;
    } op_point_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_VOLT_FIRST,
        SQ_RELOCK,
        SQ_VOLT_LAST
    } seq_state_t;

    // Higher ratio wins; equal ratios resolve to the higher voltage code.
    function automatic op_point_t pick_higher(op_point_t a, op_point_t b);
        if (a.ratio > b.ratio) return a;
        if (b.ratio > a.ratio) return b;
        return (a.vid >= b.vid) ? a : b;
    endfunction

    // One code toward the goal.
    function automatic logic [VID_W-1:0] vid_toward(logic [VID_W-1:0] cur,
                                                    logic [VID_W-1:0] goal);
        if (cur < goal) return cur + 1'b1;
        if (cur > goal) return cur - 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/pstate_resolve.sv
module pstate_resolve
    import pstate_pkg::*;
#(
    parameter int LOW_RATIO = 6,
    parameter int LOW_VID   = 10
) (
    input  op_point_t req0,
    input  op_point_t req1,
    input  logic      ext_idle,
    output op_point_t target
);
    op_point_t merged;
    op_point_t low_pt;

    always_comb begin
        low_pt.ratio = RATIO_W'(LOW_RATIO);
        low_pt.vid   = VID_W'(LOW_VID);
        merged       = pick_higher(req0, req1);
        target       = ext_idle ? low_pt : merged;
    end
endmodule

// File: rtl/pstate_step_timer.sv
module pstate_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hold,
    input  logic [CNT_W-1:0] step_cycles,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (step_cycles == '0) ? CNT_W'(1) : step_cycles;
        tick  = en && !hold && (cnt == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= cnt;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
    import pstate_pkg::*;
#(
    parameter int LOW_RATIO = 6,
    parameter int LOW_VID   = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  op_point_t target,
    input  logic      pkg_sleep,
    input  logic      pll_locked,
    input  logic      step_tick,
    output op_point_t cur,
    output logic      step_en,
    output logic      busy,
    output logic      relock_req
);
    seq_state_t state;
    op_point_t  goal;
    logic       dir_up;
    logic       in_volt;

    always_comb begin
        in_volt    = (state == SQ_VOLT_FIRST) || (state == SQ_VOLT_LAST);
        step_en    = in_volt && (cur.vid != goal.vid);
        busy       = (state != SQ_IDLE);
        relock_req = (state == SQ_RELOCK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            cur.ratio  <= RATIO_W'(LOW_RATIO);
            cur.vid    <= VID_W'(LOW_VID);
            goal.ratio <= RATIO_W'(LOW_RATIO);
            goal.vid   <= VID_W'(LOW_VID);
            dir_up     <= 1'b0;
        end else if (!pkg_sleep) begin
            unique case (state)
                SQ_IDLE: begin
                    if (target != cur) begin
                        goal   <= target;
                        dir_up <= (target.ratio > cur.ratio);
                        if (target.ratio > cur.ratio) begin
                            state <= SQ_VOLT_FIRST;
                        end else if (target.ratio < cur.ratio) begin
                            state     <= SQ_RELOCK;
                            cur.ratio <= target.ratio;
                        end else begin
                            state <= SQ_VOLT_LAST;
                        end
                    end
                end
                SQ_VOLT_FIRST: begin
                    if (cur.vid == goal.vid) begin
                        state     <= SQ_RELOCK;
                        cur.ratio <= goal.ratio;
                    end else if (step_tick) begin
                        cur.vid <= vid_toward(cur.vid, goal.vid);
                    end
                end
                SQ_RELOCK: begin
                    if (pll_locked) state <= dir_up ? SQ_IDLE : SQ_VOLT_LAST;
                end
                SQ_VOLT_LAST: begin
                    if (cur.vid == goal.vid) begin
                        state <= SQ_IDLE;
                    end else if (step_tick) begin
                        cur.vid <= vid_toward(cur.vid, goal.vid);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pstate_coord.sv
module pstate_coord
    import pstate_pkg::*;
#(
    parameter int LOW_RATIO = 6,
    parameter int LOW_VID   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] core0_ratio,
    input  logic [VID_W-1:0]   core0_vid,
    input  logic [RATIO_W-1:0] core1_ratio,
    input  logic [VID_W-1:0]   core1_vid,
    input  logic               ext_idle,
    input  logic               pkg_sleep,
    input  logic               pll_locked,
    input  logic [CNT_W-1:0]   step_cycles,
    output logic [VID_W-1:0]   vid_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               relock_req,
    output logic               busy
);
    op_point_t req0, req1, target, cur;
    logic      step_en, step_tick;

    always_comb begin
        req0.ratio = core0_ratio;
        req0.vid   = core0_vid;
        req1.ratio = core1_ratio;
        req1.vid   = core1_vid;
        vid_out    = cur.vid;
        ratio_out  = cur.ratio;
    end

    pstate_resolve #(.LOW_RATIO(LOW_RATIO), .LOW_VID(LOW_VID)) u_resolve (
        .req0     (req0),
        .req1     (req1),
        .ext_idle (ext_idle),
        .target   (target)
    );

    pstate_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .en          (step_en),
        .hold        (pkg_sleep),
        .step_cycles (step_cycles),
        .tick        (step_tick)
    );

    pstate_seq #(.LOW_RATIO(LOW_RATIO), .LOW_VID(LOW_VID)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .target     (target),
        .pkg_sleep  (pkg_sleep),
        .pll_locked (pll_locked),
        .step_tick  (step_tick),
        .cur        (cur),
        .step_en    (step_en),
        .busy       (busy),
        .relock_req (relock_req)
    );
endmodule

// File: rtl/pstate_coord_chk.sv
module pstate_coord_chk
    import pstate_pkg::*;
#(
    parameter int LOW_RATIO = 6,
    parameter int LOW_VID   = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               pkg_sleep,
    input logic               pll_locked,
    input logic [VID_W-1:0]   vid_out,
    input logic [RATIO_W-1:0] ratio_out,
    input logic               relock_req,
    input logic               busy
);
    logic [VID_W-1:0]   vid_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               ratio_went_up;
    logic               vid_went_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_q         <= VID_W'(LOW_VID);
            ratio_q       <= RATIO_W'(LOW_RATIO);
            ratio_went_up <= 1'b0;
            vid_went_down <= 1'b0;
        end else begin
            vid_q   <= vid_out;
            ratio_q <= ratio_out;
            if (!busy) begin
                ratio_went_up <= 1'b0;
                vid_went_down <= 1'b0;
            end else begin
                if (ratio_out > ratio_q) ratio_went_up <= 1'b1;
                if (vid_out < vid_q)     vid_went_down <= 1'b1;
            end
        end
    end

    p_reset_point_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vid_out == VID_W'(LOW_VID)) && (ratio_out == RATIO_W'(LOW_RATIO))
                       && !busy && !relock_req);

    p_up_vid_settled_r2: assert property (@(posedge clk) disable iff (rst)
        ratio_went_up |-> $stable(vid_out));

    p_dn_ratio_settled_r3: assert property (@(posedge clk) disable iff (rst)
        vid_went_down |-> $stable(ratio_out));

    p_vid_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        $changed(vid_out) |-> (vid_out == $past(vid_out) + 1'b1) || (vid_out == $past(vid_out) - 1'b1));

    p_change_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
        ($changed(vid_out) || $changed(ratio_out)) |-> busy);

    p_ratio_with_relock_r6: assert property (@(posedge clk) disable iff (rst)
        $changed(ratio_out) |-> relock_req);

    p_relock_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (relock_req && !pll_locked) |=> relock_req);

    p_frozen_sleep_r9: assert property (@(posedge clk) disable iff (rst)
        $past(pkg_sleep) |-> $stable(vid_out) && $stable(ratio_out) && $stable(busy));
endmodule

bind pstate_coord pstate_coord_chk #(.LOW_RATIO(LOW_RATIO), .LOW_VID(LOW_VID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pkg_sleep  (pkg_sleep),
    .pll_locked (pll_locked),
    .vid_out    (vid_out),
    .ratio_out  (ratio_out),
    .relock_req (relock_req),
    .busy       (busy)
);

// File: tb/tb_pstate_coord.sv
module tb_pstate_coord;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] core0_ratio = 5'd6, core1_ratio = 5'd6;
    logic [6:0] core0_vid = 7'd10, core1_vid = 7'd10;
    logic       ext_idle = 1'b0, pkg_sleep = 1'b0;
    logic       model_lock = 1'b0, stray_lock = 1'b0;
    logic       pll_locked;
    logic [7:0] step_cycles = 8'd2;
    logic [6:0] vid_out;
    logic [4:0] ratio_out;
    logic       relock_req, busy;
    int checks = 0, fails = 0;
    bit finished = 0;

    assign pll_locked = model_lock | stray_lock;
    always #5 clk = ~clk;

    pstate_coord dut (
        .clk(clk), .rst(rst),
        .core0_ratio(core0_ratio), .core0_vid(core0_vid),
        .core1_ratio(core1_ratio), .core1_vid(core1_vid),
        .ext_idle(ext_idle), .pkg_sleep(pkg_sleep), .pll_locked(pll_locked),
        .step_cycles(step_cycles), .vid_out(vid_out), .ratio_out(ratio_out),
        .relock_req(relock_req), .busy(busy)
    );

    // Fields: core0 ratio, core0 vid, core1 ratio, core1 vid, expected ratio, expected vid, step
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{12, 20,  8, 15, 12, 20, 2},   // up, core0 wins
        '{ 9, 16,  7, 14,  9, 16, 3},   // down
        '{ 9, 16, 14, 24, 14, 24, 1},   // up, core1 wins
        '{10, 19, 10, 22, 10, 22, 2},   // down, equal ratios -> higher vid
        '{10, 17, 10, 12, 10, 17, 2},   // voltage-only move
        '{ 6, 10,  6, 10,  6, 10, 4}    // back to lowest
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // PLL model: answers a relock request with a one-cycle lock pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (relock_req && !pkg_sleep) begin
                repeat (4) @(negedge clk);
                chk(relock_req == 1'b1, "R6 relock held until lock", int'(relock_req), 1);
                model_lock = 1'b1;
                @(negedge clk);
                model_lock = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL WATCHDOG actual=timeout expected=completion");
        summary();
    end

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, tag, n, 5000);
    endtask

    task automatic run_xfer(input int er, input int ev, input int st, input string tag);
        int cyc = 0, w = 0, rchg = -1, vfirst = -1, vlast = -1;
        int pr, pv, eff, d;
        bit up, dn, bad_step = 0, bad_space = 0;
        eff = (st == 0) ? 1 : st;
        up = er > int'(ratio_out);
        dn = er < int'(ratio_out);
        pr = int'(ratio_out);
        pv = int'(vid_out);
        while (!busy && w < 6) begin @(negedge clk); w++; end
        if (busy && int'(ratio_out) != pr) begin rchg = 0; pr = int'(ratio_out); end
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (int'(ratio_out) != pr) begin
                if (rchg < 0) rchg = cyc;
                pr = int'(ratio_out);
            end
            if (int'(vid_out) != pv) begin
                d = int'(vid_out) - pv;
                if (d != 1 && d != -1) bad_step = 1;
                if (vlast >= 0 && cyc - vlast != eff) bad_space = 1;
                if (vfirst < 0) vfirst = cyc;
                vlast = cyc;
                pv = int'(vid_out);
            end
        end
        chk(cyc < 5000, {tag, " completion"}, cyc, 5000);
        chk(int'(ratio_out) == er, {tag, " ratio (R1)"}, int'(ratio_out), er);
        chk(int'(vid_out) == ev, {tag, " vid (R1)"}, int'(vid_out), ev);
        chk(!bad_step, {tag, " R4 single-code steps"}, int'(bad_step), 0);
        chk(!bad_space, {tag, " R4 step spacing"}, int'(bad_space), 0);
        if (up) chk(rchg > vlast, {tag, " R2 voltage before ratio"}, rchg, vlast + 1);
        if (dn) chk(rchg >= 0 && (vfirst < 0 || rchg < vfirst),
                    {tag, " R3 ratio before voltage"}, rchg, vfirst);
    endtask

    initial begin
        int sv, sr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(vid_out == 7'd10, "R10 vid after reset", int'(vid_out), 10);
        chk(ratio_out == 5'd6, "R10 ratio after reset", int'(ratio_out), 6);
        chk(!busy && !relock_req, "R10 busy/relock after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            core0_ratio = 5'(VEC[i][0]); core0_vid = 7'(VEC[i][1]);
            core1_ratio = 5'(VEC[i][2]); core1_vid = 7'(VEC[i][3]);
            step_cycles = 8'(VEC[i][6]);
            run_xfer(VEC[i][4], VEC[i][5], VEC[i][6], $sformatf("VEC%0d", i));
        end

        // R7 deferral
        step_cycles = 8'd2;
        core0_ratio = 5'd14; core0_vid = 7'd24;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R5 busy during move", int'(busy), 1);
        core0_ratio = 5'd16; core0_vid = 7'd26;
        wait_idle("R7 first move");
        chk(ratio_out == 5'd14 && vid_out == 7'd24, "R7 first target kept", int'(vid_out), 24);
        @(negedge clk);
        chk(busy == 1'b1, "R7 deferred move starts", int'(busy), 1);
        wait_idle("R7 second move");
        chk(ratio_out == 5'd16 && vid_out == 7'd26, "R7 deferred target", int'(vid_out), 26);

        // R8 extended idle
        ext_idle = 1'b1;
        run_xfer(6, 10, 2, "R8 idle entry");
        ext_idle = 1'b0;
        run_xfer(16, 26, 2, "R8 idle exit");

        // R9 freeze in sleep mid-move
        step_cycles = 8'd5;
        core0_ratio = 5'd8; core0_vid = 7'd14;
        repeat (16) @(negedge clk);
        pkg_sleep = 1'b1;
        sv = int'(vid_out); sr = int'(ratio_out);
        repeat (20) @(negedge clk);
        chk(int'(vid_out) == sv && int'(ratio_out) == sr, "R9 outputs frozen", int'(vid_out), sv);
        chk(busy == 1'b1, "R9 busy held in sleep", int'(busy), 1);
        pkg_sleep = 1'b0;
        wait_idle("R9 resume");
        chk(ratio_out == 5'd8 && vid_out == 7'd14, "R9 completes after sleep", int'(vid_out), 14);

        // R9 no start in sleep
        pkg_sleep = 1'b1;
        core0_ratio = 5'd12; core0_vid = 7'd20;
        repeat (10) @(negedge clk);
        chk(!busy && ratio_out == 5'd8, "R9 no start in sleep", int'(ratio_out), 8);
        pkg_sleep = 1'b0;
        run_xfer(12, 20, 5, "R9 start after sleep");

        // R4 step_cycles of 0 behaves as 1
        step_cycles = 8'd0;
        core0_ratio = 5'd12; core0_vid = 7'd27; core1_ratio = 5'd6; core1_vid = 7'd10;
        run_xfer(12, 27, 0, "R4 zero step");

        // R5 equal target in swapped form: no move
        core0_ratio = 5'd6; core0_vid = 7'd10; core1_ratio = 5'd12; core1_vid = 7'd27;
        repeat (8) @(negedge clk);
        chk(!busy && vid_out == 7'd27 && ratio_out == 5'd12, "R5 no move on equal target",
            int'(busy), 0);

        // R6 stray lock pulse while idle
        stray_lock = 1'b1;
        @(negedge clk);
        stray_lock = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !relock_req && vid_out == 7'd27 && ratio_out == 5'd12,
            "R6 stray lock ignored", int'(busy), 0);

        summary();
    end
endmodule